// File: doc/BRIEF.md
# Masked-Address GPIO Register Block

This block is the register front end of an eight-pin general-purpose I/O peripheral. It sits on a simple synchronous register bus with byte-wide data. The lower part of the address map is a data window. In that window, address bits [9:2] form a per-pin mask, so software can read or write any subset of pins in one access, without a read-modify-write sequence. Above the data window sit a direction register and a bank of interrupt configuration and status registers.

The block drives the pin output values and output enables. It synchronises the pin inputs and reads them back. It exports the interrupt configuration to an external edge/level detection unit, and it reads that unit's raw status. A write to the clear register sends a one-cycle clear pulse to the detection unit. Pads and the detection logic itself sit outside this block.

Top module: `gpio_mask_top`

## Requirements
- R1: After synchronous reset, every register holds zero. `pin_oe`, `pin_out`, all `det_*` outputs and `bus_rdata` are zero, so every pin is an input.
- R2: The register at byte offset 0x400 holds the direction. Bit n = 1 makes pin n an output, and `pin_oe` equals this register in the cycle after the write. The register reads back its written value.
- R3: In the data window (offsets 0x000–0x3FC, bits [11:10] = 0), address bit n+2 selects pin n. A write updates `pin_out` bit n only where that mask bit is 1 and leaves all other pins unchanged.
- R4: A data write to a pin whose direction bit is 0 has no effect. If the pin is later switched to output, it keeps its old output value until it is written again.
- R5: A data-window read returns zero in every unmasked bit position. In masked positions it returns the driven output value for output pins and the synchronised pin level for input pins. A pin change becomes visible to a read issued SYNC_STAGES+1 cycles after the change, and not to one issued the cycle after it.
- R6: The offsets 0x404 (sense), 0x408 (both edges), 0x40C (polarity) and 0x410 (enable) are read/write. They drive `det_sense`, `det_both`, `det_polarity` and `det_enable` from the cycle after the write.
- R7: Offset 0x414 reads `det_raw`, and offset 0x418 reads `det_raw & det_enable`. Both are read-only, and writes to them change no register.
- R8: A write to offset 0x41C pulses `det_clear` with the written byte for exactly one cycle after the write. Reads of 0x41C return zero.
- R9: Unmapped offsets read zero and ignore writes. These are offsets 0x420–0x7FF, offsets with bit 11 set, and any offset with address bits [1:0] non-zero.
- R10: `bus_rdata` carries the read result in the cycle after `bus_rd` is high and is zero in any cycle after a cycle without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables (1 = drive) |
| det_raw | input | 8 | Raw interrupt status from the detection unit |
| det_sense | output | 8 | Level (1) or edge (0) sense per pin |
| det_both | output | 8 | Trigger on both edges per pin |
| det_polarity | output | 8 | High/rising (1) or low/falling (0) per pin |
| det_enable | output | 8 | Interrupt enable per pin |
| det_clear | output | 8 | One-cycle interrupt clear pulse per pin |

## Verification
The masked data path is driven with single-pin masks, sparse two-pin masks and the full mask. These patterns show whether the address bits decode to the correct pins and whether unmasked pins really keep their values. Writes to input-only pins, and reads of a mixed input/output configuration, show whether the direction register gates the writes and selects the read source for each pin. A pin change followed by back-to-back reads shows the synchroniser latency. Misaligned, out-of-range and read-only offsets are written, then read back, to show that they leave the state unchanged.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int PIN_N  = 8;
    localparam int ADDR_N = 12;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_IEN,
        SEL_RAW,
        SEL_MIS,
        SEL_CLR
    } sel_e;

    // Register index inside the control bank (offset bits [4:2]).
    function automatic sel_e bank_sel(input logic [2:0] idx);
        sel_e s;
        case (idx)
            3'd0:    s = SEL_DIR;
            3'd1:    s = SEL_SENSE;
            3'd2:    s = SEL_BOTH;
            3'd3:    s = SEL_POL;
            3'd4:    s = SEL_IEN;
            3'd5:    s = SEL_RAW;
            3'd6:    s = SEL_MIS;
            default: s = SEL_CLR;
        endcase
        return s;
    endfunction

    // Merge new bits into a word only where the enable is set.
    function automatic logic [PIN_N-1:0] merge_bits(
        input logic [PIN_N-1:0] old_v,
        input logic [PIN_N-1:0] new_v,
        input logic [PIN_N-1:0] en
    );
        return (old_v & ~en) | (new_v & en);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_mask_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [PINS-1:0]   mask
);
    localparam int HI_LSB = PINS + 2;
    localparam int HI_W   = ADDR_W - HI_LSB;

    logic [HI_W-1:0] hi;

    assign hi   = addr[ADDR_W-1:HI_LSB];
    assign mask = addr[PINS+1:2];

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (hi == '0) begin
                sel = SEL_DATA;
            end else if (hi == HI_W'(1) && addr[PINS+1:5] == '0) begin
                sel = bank_sel(addr[4:2]);
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mask_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  sel_e            sel,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] sense_q,
    output logic [PINS-1:0] both_q,
    output logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] ien_q,
    output logic [PINS-1:0] clr_q
);
    logic [PINS-1:0] data_en;

    // Only pins that are masked in and currently outputs accept data.
    assign data_en = mask & dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            out_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            ien_q   <= '0;
            clr_q   <= '0;
        end else begin
            clr_q <= '0;
            if (wr) begin
                case (sel)
                    SEL_DATA:  out_q   <= (out_q & ~data_en) | (wdata & data_en);
                    SEL_DIR:   dir_q   <= wdata;
                    SEL_SENSE: sense_q <= wdata;
                    SEL_BOTH:  both_q  <= wdata;
                    SEL_POL:   pol_q   <= wdata;
                    SEL_IEN:   ien_q   <= wdata;
                    SEL_CLR:   clr_q   <= wdata;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_mask_top.sv
module gpio_mask_top
    import gpio_mask_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   det_raw,
    output logic [PINS-1:0]   det_sense,
    output logic [PINS-1:0]   det_both,
    output logic [PINS-1:0]   det_polarity,
    output logic [PINS-1:0]   det_enable,
    output logic [PINS-1:0]   det_clear
);
    sel_e            sel;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] dir_q, out_q;
    logic [PINS-1:0] rd_val;
    logic [PINS-1:0] rdata_q;

    gpio_addr_dec #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .mask (mask)
    );

    gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .sel     (sel),
        .mask    (mask),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .sense_q (det_sense),
        .both_q  (det_both),
        .pol_q   (det_polarity),
        .ien_q   (det_enable),
        .clr_q   (det_clear)
    );

    always_comb begin
        case (sel)
            SEL_DATA:  rd_val = mask & merge_bits(pin_sync, out_q, dir_q);
            SEL_DIR:   rd_val = dir_q;
            SEL_SENSE: rd_val = det_sense;
            SEL_BOTH:  rd_val = det_both;
            SEL_POL:   rd_val = det_polarity;
            SEL_IEN:   rd_val = det_enable;
            SEL_RAW:   rd_val = det_raw;
            SEL_MIS:   rd_val = det_raw & det_enable;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= bus_rd ? rd_val : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;
    assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   det_raw,
    input logic [PINS-1:0]   det_enable,
    input logic [PINS-1:0]   det_clear
);
    localparam logic [ADDR_W-1:0] BANK     = ADDR_W'(1 << (PINS + 2));
    localparam logic [ADDR_W-1:0] DIR_OFS  = BANK;
    localparam logic [ADDR_W-1:0] MIS_OFS  = BANK + ADDR_W'(24);
    localparam logic [ADDR_W-1:0] CLR_OFS  = BANK + ADDR_W'(28);

    logic live;
    logic wr_dir, wr_clr, wr_data, rd_mis;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    assign wr_dir  = bus_wr && bus_addr == DIR_OFS;
    assign wr_clr  = bus_wr && bus_addr == CLR_OFS;
    assign wr_data = bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:PINS+2] == '0;
    assign rd_mis  = bus_rd && bus_addr == MIS_OFS;

    p_dir_oe_r2: assert property (@(posedge clk) disable iff (rst || !live)
        $past(wr_dir) |-> pin_oe == $past(bus_wdata));

    p_mask_write_r3: assert property (@(posedge clk) disable iff (rst || !live)
        $past(wr_data) |-> ((pin_out ^ $past(pin_out)) & ~$past(bus_addr[PINS+1:2])) == '0);

    p_input_hold_r4: assert property (@(posedge clk) disable iff (rst || !live)
        ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

    p_mis_subset_r7: assert property (@(posedge clk) disable iff (rst || !live)
        $past(rd_mis) |-> (bus_rdata & ~($past(det_raw) & $past(det_enable))) == '0);

    p_clear_src_r8: assert property (@(posedge clk) disable iff (rst || !live)
        (det_clear != '0) |-> ($past(wr_clr) && det_clear == $past(bus_wdata)));

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (rst || !live)
        !$past(bus_rd) |-> bus_rdata == '0);

endmodule

bind gpio_mask_top gpio_mask_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .det_raw    (det_raw),
    .det_enable (det_enable),
    .det_clear  (det_clear)
);

// File: tb/sim_gpio_mask_top.sv
`timescale 1ns/1ps
module sim_gpio_mask_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic [7:0]  det_raw = '0;
    logic [7:0]  det_sense, det_both, det_polarity, det_enable, det_clear;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic rd_q = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    gpio_mask_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .det_raw(det_raw),
        .det_sense(det_sense), .det_both(det_both), .det_polarity(det_polarity),
        .det_enable(det_enable), .det_clear(det_clear)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected value to the scoreboard.
    task automatic bus_read(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: compares the read result in the cycle after each read strobe.
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected read data", 8'h00, 8'hFF);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 det_enable", det_enable, 8'h00);
        chk("R1 det_sense", det_sense | det_both | det_polarity | det_clear, 8'h00);
        chk("R1 bus_rdata", bus_rdata, 8'h00);
        bus_read(12'h400, 8'h00, "R1 dir after reset");
        bus_read(12'h410, 8'h00, "R1 enable after reset");

        // R4 write to input pins ignored
        bus_write(12'h3FC, 8'hFF);
        chk("R4 write to inputs", pin_out, 8'h00);
        bus_write(12'h400, 8'hFF);
        chk("R2 pin_oe all out", pin_oe, 8'hFF);
        chk("R4 value kept after switch", pin_out, 8'h00);
        bus_read(12'h400, 8'hFF, "R2 dir readback");

        // R3 masked writes
        bus_write(12'h014, 8'hFF);
        chk("R3 mask pins 0,2", pin_out, 8'h05);
        bus_write(12'h3FC, 8'hA0);
        chk("R3 full mask", pin_out, 8'hA0);
        bus_write(12'h200, 8'h00);
        chk("R3 mask pin 7", pin_out, 8'h20);

        // R5 masked reads of outputs
        bus_read(12'h3FC, 8'h20, "R5 full read");
        bus_read(12'h080, 8'h20, "R5 pin5 read");
        bus_read(12'h040, 8'h00, "R5 pin4 read");
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 8'h00);

        // R5 mixed direction and input sync
        bus_write(12'h400, 8'h0F);
        pin_in = 8'hC3;
        repeat (4) @(negedge clk);
        bus_read(12'h3FC, 8'hC0, "R5 mixed read");
        bus_read(12'h100, 8'h40, "R5 pin6 input read");
        pin_in = 8'h10;
        bus_read(12'h3FC, 8'hC0, "R5 sync old value");
        bus_read(12'h3FC, 8'h10, "R5 sync new value");
        bus_write(12'h3FC, 8'hFF);
        chk("R4 mixed write", pin_out, 8'h2F);

        // R6 configuration registers
        bus_write(12'h404, 8'h11);
        bus_write(12'h408, 8'h22);
        bus_write(12'h40C, 8'h33);
        bus_write(12'h410, 8'h44);
        chk("R6 det_sense", det_sense, 8'h11);
        chk("R6 det_both", det_both, 8'h22);
        chk("R6 det_polarity", det_polarity, 8'h33);
        chk("R6 det_enable", det_enable, 8'h44);
        bus_read(12'h404, 8'h11, "R6 sense readback");
        bus_read(12'h408, 8'h22, "R6 both readback");
        bus_read(12'h40C, 8'h33, "R6 polarity readback");
        bus_read(12'h410, 8'h44, "R6 enable readback");

        // R7 status
        det_raw = 8'h6C;
        bus_read(12'h414, 8'h6C, "R7 raw status");
        bus_read(12'h418, 8'h44, "R7 masked status");
        bus_write(12'h414, 8'hFF);
        bus_write(12'h418, 8'hFF);
        bus_read(12'h410, 8'h44, "R7 write to status ignored");
        bus_read(12'h414, 8'h6C, "R7 raw after write");

        // R8 clear pulse
        bus_write(12'h41C, 8'h81);
        chk("R8 clear pulse", det_clear, 8'h81);
        @(negedge clk);
        chk("R8 clear one cycle", det_clear, 8'h00);
        bus_read(12'h41C, 8'h00, "R8 clear reads zero");

        // R9 unmapped
        bus_write(12'h420, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_write(12'h401, 8'hFF);
        bus_write(12'h3FD, 8'h00);
        chk("R9 misaligned data write", pin_out, 8'h2F);
        bus_read(12'h400, 8'h0F, "R9 dir unchanged");
        bus_read(12'h420, 8'h00, "R9 read 0x420");
        bus_read(12'h800, 8'h00, "R9 read 0x800");
        bus_read(12'h402, 8'h00, "R9 misaligned read");

        bus_write(12'h400, 8'h00);
        chk("R2 pin_oe cleared", pin_oe, 8'h00);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule